// File: doc/BRIEF.md
# Sixteen-Times Oversampling Serial Byte Receiver

This block receives asynchronous serial bytes for a small 8-bit processor bus. The RX line idles high. It is resynchronised into the core clock domain. It is then watched on each pulse of a sampling enable that runs at sixteen times the baud rate. A falling edge arms the receiver. The start bit is checked again half a bit later, and a line that has gone back high by then is treated as noise. After that, one sample is taken in the middle of each bit period. The data bits arrive least significant bit first.

Once the stop bit has been sampled, the assembled byte is copied into a hold register and a ready flag is raised. A low stop bit still delivers the byte, but it also raises a framing-error flag. The processor polls a status register at bus offset 0 and reads the byte at offset 1. Reading the byte clears both flags. Baud-rate generation, parity and buffering beyond one byte are left to the surrounding system.

Top module: `os_uart_rx`

## Requirements
- R1: After reset, a read at offset 0 (status) returns 0x00 and a read at offset 1 (data) returns 0x00.
- R2: A high-to-low change of the synchronised line, seen on a sampling pulse while the receiver is idle, arms the receiver. If the line is high again at the start-bit midpoint (eight sampling pulses later), the event is dropped, no byte is delivered and the receiver waits for the next falling edge. A low pulse shorter than half a bit therefore yields nothing.
- R3: The eight data bits are sampled at their midpoints, sixteen sampling pulses apart, and assembled least significant bit first. Frames whose bit period is off by about 3% in either direction are still received correctly.
- R4: After the stop-bit sample, the byte is placed in the hold register and status bit 0 (ready) reads 1. A status read does not change any flag.
- R5: A read at offset 1 returns the hold register and clears status bit 0 and status bit 1 from the next cycle on.
- R6: If a byte completes in the same cycle as a data read, the ready flag ends up set.
- R7: A stop bit sampled low still delivers the byte and sets status bit 1 (framing error) together with bit 0. A stop bit sampled high leaves bit 1 at 0. Status bits 7..2 always read 0.
- R8: A new byte that completes before the previous one is read overwrites the hold register, and ready stays set.
- R9: After a frame ends, a line that stays low does not re-arm the receiver. A new frame needs the line to go high and then fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle enable pulse at sixteen times the baud rate |
| rxIn | input | 1 | Asynchronous serial line, idle high |
| busAddr | input | 1 | Register select: 0 status, 1 data |
| busRd | input | 1 | Read strobe, one cycle per access |
| busData | output | 8 | Read data for the selected register |

## Verification
A byte can complete in the same clock cycle as a processor read of the data register, which is a clash between the set and the clear of the ready flag. To provoke it, the bench holds the data read asserted on every cycle while a frame arrives. It releases the read at the first falling clock edge where the new byte shows on the read bus, so the last read it issued coincided with the cycle in which the byte was loaded. The case passes when a following status read shows ready still set and the data still readable.

// File: rtl/os_uart_rx_pkg.sv
package os_uart_rx_pkg;

  // Strobes from the receive sequencer to the datapath
  typedef struct packed {
    logic shift;      // take sampleBit into the shift register
    logic sampleBit;  // line level at the current mid-bit point
    logic deliver;    // stop bit sampled: move byte to hold register
    logic stopOk;     // stop bit level at the deliver point
    logic abort;      // start bit rejected as noise
  } rxStrobes_t;

endpackage

// File: rtl/os_uart_rx_ctrl.sv
module os_uart_rx_ctrl
  import os_uart_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxIn,
  output rxStrobes_t strb
);

  localparam int PHASE_W  = $clog2(OSR);
  localparam int MID      = OSR / 2 - 1;
  localparam int LAST_BIT = DATA_BITS + 1;
  localparam int CNT_W    = $clog2(DATA_BITS + 2);

  logic [1:0]         syncQ;
  logic               rxLine;
  logic               prevQ;
  logic               armedQ;
  logic [PHASE_W-1:0] phaseQ;
  logic [CNT_W-1:0]   bitCntQ;
  logic               startEdge;
  logic               midPoint;
  logic               atStart;
  logic               atStop;

  assign rxLine    = syncQ[1];
  assign startEdge = sampleTick && prevQ && !rxLine && !armedQ;
  assign midPoint  = sampleTick && armedQ && (phaseQ == PHASE_W'(MID));
  assign atStart   = (bitCntQ == '0);
  assign atStop    = (bitCntQ == CNT_W'(LAST_BIT));

  // Two-flop synchronizer and last sampled level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= 2'b11;
      prevQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rxIn};
      if (sampleTick) prevQ <= rxLine;
    end
  end

  // Set/reset arm flop: set by start edge, cleared on abort or end of frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else if (startEdge) begin
      armedQ <= 1'b1;
    end else if (midPoint && ((atStart && rxLine) || atStop)) begin
      armedQ <= 1'b0;
    end
  end

  // First counter: position inside the bit period
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (startEdge) begin
      phaseQ <= '0;
    end else if (sampleTick && armedQ) begin
      if (phaseQ == PHASE_W'(OSR - 1)) phaseQ <= '0;
      else                             phaseQ <= phaseQ + 1'b1;
    end
  end

  // Second counter: bit index, stepped by the mid-bit enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCntQ <= '0;
    end else if (midPoint) begin
      if ((atStart && rxLine) || atStop) bitCntQ <= '0;
      else                               bitCntQ <= bitCntQ + 1'b1;
    end
  end

  always_comb begin
    strb           = '0;
    strb.sampleBit = rxLine;
    strb.stopOk    = rxLine;
    strb.shift     = midPoint && !atStart && !atStop;
    strb.deliver   = midPoint && atStop;
    strb.abort     = midPoint && atStart && rxLine;
  end

  AST_ARM_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armedQ) |-> (phaseQ == '0)); // R2

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCntQ <= CNT_W'(LAST_BIT)); // R3

  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    !armedQ |-> (bitCntQ == '0)); // R9

  AST_NO_REARM_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!armedQ && !prevQ) |=> !armedQ); // R9

endmodule

// File: rtl/os_uart_rx_dp.sv
module os_uart_rx_dp
  import os_uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int BUS_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobes_t       strb,
  input  logic             busAddr,
  input  logic             busRd,
  output logic [BUS_W-1:0] busData
);

  localparam int SC_W = $clog2(DATA_BITS + 2);

  logic [DATA_BITS-1:0] shiftQ;
  logic [DATA_BITS-1:0] holdQ;
  logic                 readyQ;
  logic                 ferrQ;
  logic                 dataRead;
  logic [SC_W-1:0]      shiftsSeen;

  assign dataRead = busRd && busAddr;

  // Serial-in shift register, LSB arrives first and ends at bit 0
  generate
    if (DATA_BITS > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (!rstN)           shiftQ <= '0;
        else if (strb.shift) shiftQ <= {strb.sampleBit, shiftQ[DATA_BITS-1:1]};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN)           shiftQ <= '0;
        else if (strb.shift) shiftQ <= strb.sampleBit;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)             holdQ <= '0;
    else if (strb.deliver) holdQ <= shiftQ;
  end

  // Flags: completion of a byte beats a concurrent read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      ferrQ  <= 1'b0;
    end else if (strb.deliver) begin
      readyQ <= 1'b1;
      ferrQ  <= !strb.stopOk;
    end else if (dataRead) begin
      readyQ <= 1'b0;
      ferrQ  <= 1'b0;
    end
  end

  always_comb begin
    if (busAddr) busData = BUS_W'(holdQ);
    else         busData = BUS_W'({ferrQ, readyQ});
  end

  // Shift events since the last frame boundary, for checking only
  always_ff @(posedge clk) begin
    if (!rstN || strb.deliver || strb.abort) shiftsSeen <= '0;
    else if (strb.shift && shiftsSeen != '1) shiftsSeen <= shiftsSeen + 1'b1;
  end

  AST_SHIFT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strb.deliver |-> (shiftsSeen == SC_W'(DATA_BITS))); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.deliver |=> readyQ); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && !strb.deliver) |=> (!readyQ && !ferrQ)); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.deliver |=> $stable(holdQ)); // R4

  AST_FERR_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    ferrQ |-> readyQ); // R7

endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx
  import os_uart_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8,
  parameter int BUS_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             rxIn,
  input  logic             busAddr,
  input  logic             busRd,
  output logic [BUS_W-1:0] busData
);

  rxStrobes_t strb;

  os_uart_rx_ctrl #(
    .OSR       (OSR),
    .DATA_BITS (DATA_BITS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .rxIn       (rxIn),
    .strb       (strb)
  );

  os_uart_rx_dp #(
    .DATA_BITS (DATA_BITS),
    .BUS_W     (BUS_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busData (busData)
  );

endmodule

// File: tb/os_uart_rx_bench.sv
`timescale 1ns/1ps
module os_uart_rx_bench;

  localparam int NOM = 64;  // 16 ticks x 4 clocks
  localparam int SLOW = 66;
  localparam int FAST = 62;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxIn = 1'b1;
  logic       busAddr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busData;

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;

  os_uart_rx u_os_uart_rx (
    .clk (clk), .rstN (rstN), .sampleTick (sampleTick), .rxIn (rxIn),
    .busAddr (busAddr), .busRd (busRd), .busData (busData)
  );

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      sampleTick = 1'b1;
      @(negedge clk);
      sampleTick = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a;
    busRd = 1'b1;
    #1 v = busData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] val, input int bitClk,
                           input logic stopLvl, input int lowBits);
    @(negedge clk);
    rxIn = 1'b0;
    repeat (bitClk) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = val[i];
      repeat (bitClk) @(negedge clk);
    end
    rxIn = stopLvl;
    repeat (bitClk) @(negedge clk);
    if (!stopLvl) repeat (lowBits * bitClk) @(negedge clk);
    rxIn = 1'b1;
    repeat (2 * bitClk) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic testReset();
    logic [7:0] v;
    readReg(1'b0, v); check("R1 status after reset", v, 8'h00);
    readReg(1'b1, v); check("R1 data after reset", v, 8'h00);
  endtask

  task automatic testNominal();
    logic [7:0] v;
    sendFrame(8'hA5, NOM, 1'b1, 0);
    readReg(1'b0, v); check("R4 ready after frame", v, 8'h01);
    readReg(1'b0, v); check("R4 status read keeps flag", v, 8'h01);
    readReg(1'b1, v); check("R3 data LSB first", v, 8'hA5);
    readReg(1'b0, v); check("R5 ready cleared by data read", v, 8'h00);
  endtask

  task automatic testBaudError();
    logic [7:0] v;
    sendFrame(8'h3C, SLOW, 1'b1, 0);
    readReg(1'b1, v); check("R3 slow baud data", v, 8'h3C);
    sendFrame(8'hC3, FAST, 1'b1, 0);
    readReg(1'b1, v); check("R3 fast baud data", v, 8'hC3);
    readReg(1'b0, v); check("R5 status after reads", v, 8'h00);
  endtask

  task automatic testGlitch();
    logic [7:0] v;
    @(negedge clk);
    rxIn = 1'b0;
    repeat (20) @(negedge clk);
    rxIn = 1'b1;
    repeat (3 * NOM) @(negedge clk);
    readReg(1'b0, v); check("R2 glitch gives no byte", v, 8'h00);
    readReg(1'b1, v); check("R2 hold unchanged by glitch", v, 8'hC3);
    sendFrame(8'h96, NOM, 1'b1, 0);
    readReg(1'b1, v); check("R2 frame after glitch", v, 8'h96);
  endtask

  task automatic testFraming();
    logic [7:0] v;
    sendFrame(8'h5A, NOM, 1'b0, 3);
    readReg(1'b0, v); check("R7 framing error status", v, 8'h03);
    readReg(1'b1, v); check("R7 byte still delivered", v, 8'h5A);
    readReg(1'b0, v); check("R5 framing flag cleared", v, 8'h00);
    repeat (12 * NOM) @(negedge clk);
    readReg(1'b0, v); check("R9 held low line gives no byte", v, 8'h00);
  endtask

  task automatic testOverwrite();
    logic [7:0] v;
    sendFrame(8'h12, NOM, 1'b1, 0);
    sendFrame(8'h34, NOM, 1'b1, 0);
    readReg(1'b0, v); check("R8 ready after overwrite", v, 8'h01);
    readReg(1'b1, v); check("R8 newest byte kept", v, 8'h34);
  endtask

  task automatic testCollision();
    logic [7:0] v;
    bit seen = 0;
    sendFrame(8'h11, NOM, 1'b1, 0);
    fork
      sendFrame(8'hEE, NOM, 1'b1, 0);
      begin
        @(negedge clk);
        busAddr = 1'b1;
        busRd = 1'b1;
        for (int n = 0; n < 20 * NOM && !seen; n++) begin
          @(negedge clk);
          #1;
          if (busData == 8'hEE) begin
            busRd = 1'b0;
            seen = 1;
          end
        end
        busRd = 1'b0;
      end
    join
    check("R6 new byte seen during reads", {7'd0, seen}, 8'h01);
    readReg(1'b0, v); check("R6 set wins over clear", v, 8'h01);
    readReg(1'b1, v); check("R6 data after collision", v, 8'hEE);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    repeat (16) @(negedge clk);
    testReset();
    testNominal();
    testBaudError();
    testGlitch();
    testFraming();
    testOverwrite();
    testCollision();
    finishRun();
  end

endmodule